// File: doc/BRIEF.md
# Wired Interrupt Source Gateway

This block sits between a set of wired interrupt lines and the priority and delivery logic of an interrupt controller. It handles sources numbered 1 to `NSRC`. Each source has a sense mode, set by a configuration write. The block turns each raw wire into an active-high "rectified" value. From that value and the mode it keeps one pending bit and one enable bit per source. Downstream logic sees a pending-and-enabled flag for every source. When that logic forwards or claims an interrupt, it returns a one-cycle strobe for that source.

Software changes the bits through a one-cycle command port. A command can name a single source by its number, or it can apply a 32-bit mask to one bitmap word. A domain-level input selects one of two delivery styles:

- **Direct delivery.** A level source's pending bit tracks its line.
- **Message delivery.** Every source becomes pending only on a low-to-high step of its rectified value. Forwarding clears the pending bit, and it stays clear while the line stays high.

The rectified values are visible as an output. After servicing a level source in message delivery, software can read this output to see whether the line is still asserted, and set pending again if it is.

Top module: `igw_gateway`

## Requirements
- R1: After reset, every source is inactive and all pending, enable and rectified bits are 0.
- R2: A configuration word whose bit 10 is set, or whose sense code (bits 2:0) is 0, 2 or 3, makes the source inactive. The other configuration bits are ignored. For an inactive source:
  - its wire is ignored and its rectified value is 0;
  - pending and enable are 0 from the cycle after the source is found inactive;
  - software set commands have no effect.
- R3: The rectified value depends on the sense code:
  - codes 4 (rising) and 6 (high): equal to the wire;
  - codes 5 (falling) and 7 (low): the inverted wire;
  - code 1 (detached) and inactive sources: 0.
- R4: For codes 4 and 5, a 0-to-1 step of the rectified value, taken against its copy registered one cycle earlier, sets pending at the next clock edge. Pending then holds until a forward strobe or a clear-pending command arrives.
- R5: In direct delivery (`msg_mode`=0), the pending bit of a code 6 or 7 source equals the previous cycle's rectified value. Forward strobes and software set or clear commands do not change it.
- R6: In message delivery (`msg_mode`=1), every live mode sets pending only on a 0-to-1 step of the rectified value, or by a software set. A forward strobe clears pending, and pending stays 0 while the level remains high.
- R7: By-number commands (`cmd_data` = source number) use these `cmd_op` codes:
  - 1: set pending;
  - 2: clear pending;
  - 3: set enable;
  - 4: clear enable.
  A number of 0 or above `NSRC` has no effect, and op codes 0 and 9 to 15 do nothing.
- R8: Bitmap commands apply `cmd_data` to word `cmd_word`, where bit b stands for source 32*`cmd_word`+b. Bit 0 of word 0 is unused. The `cmd_op` codes are:
  - 5: set pending;
  - 6: clear pending;
  - 7: set enable;
  - 8: clear enable.
  An all-ones clear-enable disables every source in that word and leaves other words unchanged.
- R9: A configuration write with `cfg_num`=k updates source k only, taking effect at the next edge. Writes with k=0 or k>`NSRC` are ignored.
- R10: `ready_o` for a source is 1 exactly when both its pending and enable bits are 1.
- R11: A detached source (code 1) ignores its wire. It can still be made pending by software, and a forward strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode | input | 1 | 1 = message delivery, 0 = direct delivery |
| src_in | input | NSRC | Raw wires, bit k-1 is source k (already synchronised) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_num | input | NUMW | Source number for the configuration write |
| cfg_word | input | 11 | Configuration word: bit 10 delegate, bits 2:0 sense code |
| cmd_valid | input | 1 | Software command strobe |
| cmd_op | input | 4 | Command code (see R7, R8) |
| cmd_word | input | WORDW | Bitmap word select |
| cmd_data | input | 32 | Source number or bitmap mask |
| fwd_i | input | NSRC | Per-source forwarded/claimed strobe |
| pend_o | output | NSRC | Pending bits |
| en_o | output | NSRC | Enable bits |
| rect_o | output | NSRC | Rectified values |
| ready_o | output | NSRC | Pending and enabled |

## Verification
The four wire sense codes are each driven through 0-to-1 and 1-to-0 steps. This separates inverted from plain rectification, and edge capture from level tracking. Level sources are held high across forward strobes in both delivery styles; only message delivery may drop pending and keep it low. The same commands are issued by number and by bitmap word, including the out-of-range numbers 0 and `NSRC`+1 and a word boundary at source 32. Reserved, delegated and detached configurations are given toggling wires and software sets to show which bits they may and may not reach.

// File: rtl/igw_pkg.sv
package igw_pkg;

    typedef enum logic [2:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RSV2   = 3'd2,
        SM_RSV3   = 3'd3,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } sense_e;

    typedef enum logic [3:0] {
        OP_NOP         = 4'd0,
        OP_SET_IP_NUM  = 4'd1,
        OP_CLR_IP_NUM  = 4'd2,
        OP_SET_IE_NUM  = 4'd3,
        OP_CLR_IE_NUM  = 4'd4,
        OP_SET_IP_WORD = 4'd5,
        OP_CLR_IP_WORD = 4'd6,
        OP_SET_IE_WORD = 4'd7,
        OP_CLR_IE_WORD = 4'd8
    } op_e;

    typedef struct packed {
        logic set_ip;
        logic clr_ip;
        logic set_ie;
        logic clr_ie;
        logic cfg_hit;
    } src_req_t;

    localparam int CFG_W      = 11;
    localparam int DELEG_BIT  = 10;

    // Delegated words and reserved codes collapse to the inactive mode.
    function automatic sense_e cfg_to_sense(input logic [CFG_W-1:0] w);
        sense_e s;
        if (w[DELEG_BIT]) begin
            s = SM_OFF;
        end else begin
            s = sense_e'(w[2:0]);
            if (s == SM_RSV2 || s == SM_RSV3) s = SM_OFF;
        end
        return s;
    endfunction

    function automatic logic sense_live(input sense_e s);
        return s != SM_OFF;
    endfunction

    function automatic logic sense_wired(input sense_e s);
        return s == SM_RISE || s == SM_FALL || s == SM_HIGH || s == SM_LOW;
    endfunction

    function automatic logic sense_inverted(input sense_e s);
        return s == SM_FALL || s == SM_LOW;
    endfunction

    function automatic logic sense_level(input sense_e s);
        return s == SM_HIGH || s == SM_LOW;
    endfunction

endpackage

// File: rtl/igw_cmd_decode.sv
module igw_cmd_decode
    import igw_pkg::*;
#(
    parameter int NSRC  = 40,
    parameter int NUMW  = 6,
    parameter int WORDW = 1
) (
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [WORDW-1:0] cmd_word,
    input  logic [31:0]      cmd_data,
    input  logic             cfg_we,
    input  logic [NUMW-1:0]  cfg_num,
    output src_req_t         req_o [NSRC]
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int NUM  = i + 1;
        localparam int WSEL = NUM / 32;
        localparam int WBIT = NUM % 32;

        logic num_hit;
        logic word_hit;

        assign num_hit  = cmd_valid && (cmd_data == 32'(NUM));
        assign word_hit = cmd_valid && (cmd_word == WORDW'(WSEL)) && cmd_data[WBIT];

        assign req_o[i] = '{
            set_ip:  (num_hit  && cmd_op == OP_SET_IP_NUM)  ||
                     (word_hit && cmd_op == OP_SET_IP_WORD),
            clr_ip:  (num_hit  && cmd_op == OP_CLR_IP_NUM)  ||
                     (word_hit && cmd_op == OP_CLR_IP_WORD),
            set_ie:  (num_hit  && cmd_op == OP_SET_IE_NUM)  ||
                     (word_hit && cmd_op == OP_SET_IE_WORD),
            clr_ie:  (num_hit  && cmd_op == OP_CLR_IE_NUM)  ||
                     (word_hit && cmd_op == OP_CLR_IE_WORD),
            cfg_hit: cfg_we && (cfg_num == NUMW'(NUM))
        };
    end

endmodule

// File: rtl/igw_src_cell.sv
module igw_src_cell
    import igw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_mode,
    input  logic             raw_i,
    input  src_req_t         req_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic             fwd_i,
    output logic             pend_o,
    output logic             en_o,
    output logic             rect_o
);

    sense_e sense_q;
    logic   rect;
    logic   rect_q;
    logic   rise;
    logic   live;
    logic   level_follow;
    logic   pend_q, pend_d;
    logic   en_q, en_d;

    always_ff @(posedge clk) begin
        if (rst)                sense_q <= SM_OFF;
        else if (req_i.cfg_hit) sense_q <= cfg_to_sense(cfg_word_i);
    end

    assign live         = sense_live(sense_q);
    assign rect         = sense_wired(sense_q) ? (raw_i ^ sense_inverted(sense_q)) : 1'b0;
    assign rise         = rect && !rect_q;
    assign level_follow = !msg_mode && sense_level(sense_q);

    always_comb begin
        if (!live)             pend_d = 1'b0;
        else if (level_follow) pend_d = rect;
        else                   pend_d = (pend_q && !(fwd_i || req_i.clr_ip)) || rise || req_i.set_ip;
    end

    always_comb begin
        en_d = live && ((en_q || req_i.set_ie) && !req_i.clr_ie);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rect_q <= 1'b0;
            pend_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            rect_q <= rect;
            pend_q <= pend_d;
            en_q   <= en_d;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign rect_o = rect;

    assert_off_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !live |=> (!pend_q && !en_q));

    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (live && !level_follow && rise) |=> pend_q);

    assert_level_track_R5: assert property (@(posedge clk) disable iff (rst)
        level_follow |=> (pend_q == $past(rect)));

    assert_msg_no_rearm_R6: assert property (@(posedge clk) disable iff (rst)
        (msg_mode && !pend_q && !rise && !req_i.set_ip) |=> !pend_q);

    assert_enable_set_R7: assert property (@(posedge clk) disable iff (rst)
        (live && req_i.set_ie && !req_i.clr_ie) |=> en_q);

endmodule

// File: rtl/igw_gateway.sv
module igw_gateway
    import igw_pkg::*;
#(
    parameter int NSRC = 40,
    localparam int NUMW  = $clog2(NSRC + 1),
    localparam int NWORD = NSRC / 32 + 1,
    localparam int WORDW = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_mode,
    input  logic [NSRC-1:0]  src_in,
    input  logic             cfg_we,
    input  logic [NUMW-1:0]  cfg_num,
    input  logic [10:0]      cfg_word,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [WORDW-1:0] cmd_word,
    input  logic [31:0]      cmd_data,
    input  logic [NSRC-1:0]  fwd_i,
    output logic [NSRC-1:0]  pend_o,
    output logic [NSRC-1:0]  en_o,
    output logic [NSRC-1:0]  rect_o,
    output logic [NSRC-1:0]  ready_o
);

    src_req_t req [NSRC];

    igw_cmd_decode #(
        .NSRC  (NSRC),
        .NUMW  (NUMW),
        .WORDW (WORDW)
    ) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_word  (cmd_word),
        .cmd_data  (cmd_data),
        .cfg_we    (cfg_we),
        .cfg_num   (cfg_num),
        .req_o     (req)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        igw_src_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .msg_mode   (msg_mode),
            .raw_i      (src_in[i]),
            .req_i      (req[i]),
            .cfg_word_i (cfg_word),
            .fwd_i      (fwd_i[i]),
            .pend_o     (pend_o[i]),
            .en_o       (en_o[i]),
            .rect_o     (rect_o[i])
        );
    end

    assign ready_o = pend_o & en_o;

endmodule

// File: tb/igw_gateway_tb.sv
module igw_gateway_tb;

    localparam int NSRC  = 40;
    localparam int NUMW  = $clog2(NSRC + 1);
    localparam int NWORD = NSRC / 32 + 1;
    localparam int WORDW = (NWORD > 1) ? $clog2(NWORD) : 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             msg_mode = 1'b0;
    logic [NSRC-1:0]  src_in = '0;
    logic             cfg_we = 1'b0;
    logic [NUMW-1:0]  cfg_num = '0;
    logic [10:0]      cfg_word = '0;
    logic             cmd_valid = 1'b0;
    logic [3:0]       cmd_op = '0;
    logic [WORDW-1:0] cmd_word = '0;
    logic [31:0]      cmd_data = '0;
    logic [NSRC-1:0]  fwd_i = '0;
    logic [NSRC-1:0]  pend_o, en_o, rect_o, ready_o;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    igw_gateway #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .msg_mode(msg_mode), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_num(cfg_num), .cfg_word(cfg_word),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_word(cmd_word),
        .cmd_data(cmd_data), .fwd_i(fwd_i),
        .pend_o(pend_o), .en_o(en_o), .rect_o(rect_o), .ready_o(ready_o)
    );

    // ---------------- behavioural reference ----------------
    int m_mode [NSRC];
    bit [NSRC-1:0] m_pend, m_en, m_rq;

    function automatic bit m_rect(int i);
        case (m_mode[i])
            4, 6:    return src_in[i];
            5, 7:    return !src_in[i];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++) m_mode[i] = 0;
            m_pend = '0; m_en = '0; m_rq = '0;
        end else begin
            bit [NSRC-1:0] np, ne, nr;
            int nm [NSRC];
            for (int i = 0; i < NSRC; i++) begin
                int n;
                bit live, r, rise, sip, cip, sie, cie, wsel, lvl;
                n    = i + 1;
                live = (m_mode[i] != 0);
                r    = m_rect(i);
                rise = r && !m_rq[i];
                wsel = cmd_valid && (int'(cmd_word) == n / 32) && cmd_data[n % 32];
                sip  = (cmd_valid && cmd_op == 1 && cmd_data == n) || (wsel && cmd_op == 5);
                cip  = (cmd_valid && cmd_op == 2 && cmd_data == n) || (wsel && cmd_op == 6);
                sie  = (cmd_valid && cmd_op == 3 && cmd_data == n) || (wsel && cmd_op == 7);
                cie  = (cmd_valid && cmd_op == 4 && cmd_data == n) || (wsel && cmd_op == 8);
                lvl  = (m_mode[i] == 6 || m_mode[i] == 7) && !msg_mode;
                if (!live)    np[i] = 1'b0;
                else if (lvl) np[i] = r;
                else          np[i] = (m_pend[i] && !(fwd_i[i] || cip)) || rise || sip;
                ne[i] = live && (m_en[i] || sie) && !cie;
                nr[i] = r;
                nm[i] = m_mode[i];
                if (cfg_we && int'(cfg_num) == n) begin
                    nm[i] = cfg_word[10] ? 0 : int'(cfg_word[2:0]);
                    if (nm[i] == 2 || nm[i] == 3) nm[i] = 0;
                end
            end
            m_pend = np; m_en = ne; m_rq = nr;
            for (int i = 0; i < NSRC; i++) m_mode[i] = nm[i];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit [NSRC-1:0] er;
            for (int i = 0; i < NSRC; i++) er[i] = m_rect(i);
            n_checks++;
            if (pend_o !== m_pend || en_o !== m_en || rect_o !== er || ready_o !== (m_pend & m_en)) begin
                n_fail++;
                $display("FAIL %s model compare: actual pend=%h en=%h rect=%h ready=%h expected pend=%h en=%h rect=%h ready=%h",
                         cur_req, pend_o, en_o, rect_o, ready_o, m_pend, m_en, er, m_pend & m_en);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
        cfg_we = 1'b0; cmd_valid = 1'b0; cmd_op = '0; fwd_i = '0;
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg(int num, logic [10:0] w);
        cfg_we = 1'b1; cfg_num = NUMW'(num); cfg_word = w;
        tick();
    endtask

    task automatic cmd(int op, int word, logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_word = WORDW'(word); cmd_data = d;
        tick();
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [NSRC-1:0] snap_p, snap_r;
        src_in = '1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cur_req = "R1";
        chk("R1", "pend after reset", 64'(pend_o), 64'd0);
        chk("R1", "en after reset", 64'(en_o), 64'd0);
        chk("R1", "rect after reset", 64'(rect_o), 64'd0);

        // wires of falling/low sources idle high so no rectified step at config
        src_in = 40'b1010;
        tick();
        cur_req = "R9";
        cfg(1, 11'd4);
        cfg(2, 11'd5);
        cfg(3, 11'd6);
        cfg(4, 11'd7);
        cfg(5, 11'd1);
        cfg(6, 11'd2);
        cfg(7, 11'h404);
        cfg(40, 11'd4);
        chk("R3", "rect with idle wires", 64'(rect_o), 64'd0);
        src_in[0] = 1'b1; src_in[1] = 1'b0;
        #0;
        chk("R3", "rect plain/inverted", 64'(rect_o[1:0]), 64'd3);

        cur_req = "R4";
        tick();
        chk("R4", "rising edge pend src1", 64'(pend_o[0]), 64'd1);
        chk("R4", "falling edge pend src2", 64'(pend_o[1]), 64'd1);
        src_in[0] = 1'b0;
        tick();
        chk("R4", "edge pend holds after wire drop", 64'(pend_o[0]), 64'd1);
        fwd_i[0] = 1'b1;
        tick();
        chk("R4", "forward clears edge pend", 64'(pend_o[0]), 64'd0);
        cmd(2, 0, 32'd2);
        chk("R4", "clear-pending-by-number src2", 64'(pend_o[1]), 64'd0);

        cur_req = "R5";
        src_in[2] = 1'b1;
        tick();
        chk("R5", "level high pend follows", 64'(pend_o[2]), 64'd1);
        fwd_i[2] = 1'b1;
        tick();
        chk("R5", "forward does not clear held level", 64'(pend_o[2]), 64'd1);
        cmd(2, 0, 32'd3);
        chk("R5", "clear cmd does not clear held level", 64'(pend_o[2]), 64'd1);
        src_in[2] = 1'b0;
        tick();
        chk("R5", "level drop clears pend", 64'(pend_o[2]), 64'd0);
        cmd(1, 0, 32'd3);
        chk("R5", "set cmd ignored on low level", 64'(pend_o[2]), 64'd0);
        src_in[3] = 1'b0;
        tick();
        chk("R5", "level low pend follows", 64'(pend_o[3]), 64'd1);
        src_in[3] = 1'b1;
        tick();

        cur_req = "R7";
        cmd(3, 0, 32'd1);
        chk("R7", "set-enable-by-number src1", 64'(en_o[0]), 64'd1);
        src_in[0] = 1'b1;
        tick();
        cur_req = "R10";
        chk("R10", "ready when pend and en", 64'(ready_o[0]), 64'd1);
        cur_req = "R7";
        cmd(4, 0, 32'd1);
        chk("R7", "clear-enable-by-number src1", 64'(en_o[0]), 64'd0);
        chk("R10", "ready drops with enable", 64'(ready_o[0]), 64'd0);
        snap_p = pend_o;
        cmd(3, 0, 32'd0);
        cmd(3, 0, 32'd41);
        cmd(1, 0, 32'd0);
        cmd(1, 0, 32'd41);
        cmd(11, 0, 32'd2);
        chk("R7", "out-of-range numbers change no enable", 64'(en_o), 64'd0);
        chk("R7", "out-of-range numbers change no pend", 64'(pend_o), 64'(snap_p));

        cur_req = "R2";
        cmd(1, 0, 32'd6);
        cmd(3, 0, 32'd6);
        cmd(1, 0, 32'd7);
        cmd(3, 0, 32'd7);
        src_in[5] = 1'b1; src_in[6] = 1'b1;
        tick();
        chk("R2", "reserved/delegated pend", 64'(pend_o[6:5]), 64'd0);
        chk("R2", "reserved/delegated en", 64'(en_o[6:5]), 64'd0);
        chk("R2", "reserved/delegated rect", 64'(rect_o[6:5]), 64'd0);

        cur_req = "R11";
        src_in[4] = 1'b1;
        tick();
        chk("R11", "detached ignores wire", 64'({rect_o[4], pend_o[4]}), 64'd0);
        cmd(1, 0, 32'd5);
        chk("R11", "detached set by software", 64'(pend_o[4]), 64'd1);
        fwd_i[4] = 1'b1;
        tick();
        chk("R11", "detached cleared by forward", 64'(pend_o[4]), 64'd0);

        cur_req = "R8";
        cmd(7, 0, 32'hFFFF_FFFF);
        chk("R8", "word0 set-enable", 64'(en_o), 64'h1F);
        cmd(7, 1, 32'h0000_0100);
        chk("R8", "word1 bit8 enables src40", 64'(en_o[39]), 64'd1);
        cmd(8, 0, 32'hFFFF_FFFF);
        chk("R8", "word0 clear-enable all ones", 64'(en_o), 64'(40'h80_0000_0000));
        cmd(5, 1, 32'h0000_0100);
        chk("R8", "word1 set-pending src40", 64'(pend_o[39]), 64'd1);
        cmd(6, 1, 32'h0000_0100);
        chk("R8", "word1 clear-pending src40", 64'(pend_o[39]), 64'd0);

        cur_req = "R6";
        msg_mode = 1'b1;
        src_in[2] = 1'b1;
        tick();
        chk("R6", "message mode level rise sets pend", 64'(pend_o[2]), 64'd1);
        fwd_i[2] = 1'b1;
        tick();
        chk("R6", "forward clears level pend", 64'(pend_o[2]), 64'd0);
        repeat (4) tick();
        chk("R6", "no re-arm while level high", 64'(pend_o[2]), 64'd0);
        chk("R6", "rect still shows level", 64'(rect_o[2]), 64'd1);
        src_in[2] = 1'b0;
        tick();
        src_in[2] = 1'b1;
        tick();
        chk("R6", "new rise re-arms", 64'(pend_o[2]), 64'd1);

        cur_req = "R9";
        snap_p = pend_o; snap_r = rect_o;
        cfg(0, 11'd6);
        cfg(41, 11'd6);
        chk("R9", "bad cfg numbers leave pend", 64'(pend_o), 64'(snap_p));
        chk("R9", "bad cfg numbers leave rect", 64'(rect_o), 64'(snap_r));
        cur_req = "R2";
        cfg(3, 11'd0);
        chk("R2", "inactive rect immediate", 64'(rect_o[2]), 64'd0);
        tick();
        chk("R2", "inactive clears pend", 64'(pend_o[2]), 64'd0);

        tick();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule